// File: doc/BRIEF.md
# Serial Channel Mode Router

This block steers bytes between four parties of a serial port: the bus-side data register, the transmit FIFO, the receive FIFO and the incoming serial line. A two-bit channel-mode field selects one of four routings: normal operation, automatic echo, local loopback and remote loopback. In normal operation, bus writes feed the transmitter and line bytes feed the receiver. In echo, every received byte is also sent back out. In local loopback, bus writes are turned around into the receive FIFO. In remote loopback, line bytes go straight back to the transmitter without software seeing them.

The router is purely a steering stage. It registers only the mode and a one-cycle overrun event. All FIFO pushes are combinational from the handshake, so a byte is pushed in the same cycle it is accepted, under the mode that was in force in that cycle. Toward the line it drives a ready signal. Ready is computed from the full flags of exactly the FIFOs the current mode targets, so no routed byte can overflow a FIFO.

Top module: `uart_chan_router`

## Requirements
- R1: After synchronous reset the active mode is normal whatever `chan_mode_cfg` holds, `tx_overrun` is low, and no push occurs while no byte is offered.
- R2: `chan_mode_cfg` carries bits 9:8 of the mode register, encoded 0 normal, 1 automatic echo, 2 local loopback, 3 remote loopback. A new value governs routing from the clock edge after it is presented; in the cycle it is presented, the old mode still applies.
- R3: In normal mode, an accepted bus write pushes its byte into the transmit FIFO in the same cycle, and an accepted line byte pushes into the receive FIFO in the same cycle.
- R4: In echo mode, an accepted line byte is pushed into both FIFOs in the same cycle with the same data, and a bus write pushes nothing.
- R5: In local loopback, a bus write pushes its byte into the receive FIFO, `line_rx_ready` is held low, and an offered line byte pushes nothing.
- R6: In remote loopback, an accepted line byte is pushed into the transmit FIFO only, and a bus write pushes nothing.
- R7: `line_rx_ready` is high only if every FIFO targeted in the current mode is not full. The receive FIFO counts in normal and echo modes, and the transmit FIFO counts in echo and remote loopback. A FIFO the mode does not target has no effect on ready.
- R8: No push is ever issued to a FIFO whose full flag is high. A bus write in local loopback while the receive FIFO is full is dropped without an event.
- R9: A bus write in normal mode, with the transmitter enabled, while the transmit FIFO is full is dropped, and `tx_overrun` is high for exactly the one cycle after it.
- R10: Any push into the transmit FIFO, from the bus or from the line, requires `tx_enable` high and `tx_disable` low. Otherwise the byte is dropped, no overrun is raised, and `line_rx_ready` is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_mode_cfg | input | 2 | Channel-mode field (mode register bits 9:8) |
| tx_enable | input | 1 | Transmitter enable control bit |
| tx_disable | input | 1 | Transmitter disable control bit |
| bus_wr_valid | input | 1 | Bus write to the data register this cycle |
| bus_wr_data | input | DATA_W | Byte written by the bus |
| line_rx_valid | input | 1 | Byte offered by the deserialiser |
| line_rx_data | input | DATA_W | Byte from the serial line |
| line_rx_ready | output | 1 | Router accepts the offered line byte this cycle |
| txf_full | input | 1 | Transmit FIFO full flag |
| txf_push | output | 1 | Push strobe into the transmit FIFO |
| txf_data | output | DATA_W | Byte pushed into the transmit FIFO |
| rxf_full | input | 1 | Receive FIFO full flag |
| rxf_push | output | 1 | Push strobe into the receive FIFO |
| rxf_data | output | DATA_W | Byte pushed into the receive FIFO |
| tx_overrun | output | 1 | One-cycle event after a bus write was dropped on a full transmit FIFO |

## Verification
Pushes, push data and line ready depend on the inputs in the same cycle. The bench therefore drives each stimulus just after a falling edge and samples one time unit later, before the next rising edge. A mode change passes through one register, so the bench checks the old routing in the cycle the field changes and the new routing after the following rising edge. The overrun event also passes through one register. It is sampled after the rising edge that follows the dropped write, and sampled again a cycle later to confirm it lasts only one cycle.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;

    typedef enum logic [1:0] {
        CH_NORMAL = 2'd0,
        CH_ECHO   = 2'd1,
        CH_LLOOP  = 2'd2,
        CH_RLOOP  = 2'd3
    } chan_mode_e;

    typedef struct packed {
        logic to_rx;
        logic to_tx;
    } route_t;

    function automatic route_t line_route(chan_mode_e m);
        route_t r;
        r.to_rx = (m == CH_NORMAL) || (m == CH_ECHO);
        r.to_tx = (m == CH_ECHO) || (m == CH_RLOOP);
        return r;
    endfunction

    function automatic route_t bus_route(chan_mode_e m);
        route_t r;
        r.to_rx = (m == CH_LLOOP);
        r.to_tx = (m == CH_NORMAL);
        return r;
    endfunction

endpackage

// File: rtl/chan_mode_reg.sv
module chan_mode_reg
    import uart_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg,
    output chan_mode_e mode_q
);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= CH_NORMAL;
        else     mode_q <= chan_mode_e'(cfg);
    end

endmodule

// File: rtl/chan_line_path.sv
module chan_line_path
    import uart_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  chan_mode_e mode,
    input  logic       line_valid,
    input  logic       rxf_full,
    input  logic       txf_full,
    input  logic       tx_ok,
    output logic       ready,
    output logic       to_rx,
    output logic       to_tx
);

    route_t rt;
    logic   accepted;

    always_comb begin
        rt       = line_route(mode);
        ready    = (rt.to_rx || rt.to_tx)
                   && !(rt.to_rx && rxf_full)
                   && !(rt.to_tx && txf_full);
        accepted = line_valid && ready;
        to_rx    = accepted && rt.to_rx;
        to_tx    = accepted && rt.to_tx && tx_ok;
    end

    a_r5_lloop_not_ready: assert property (@(posedge clk) disable iff (rst)
        (mode == CH_LLOOP) |-> !ready);

    a_r7_echo_needs_both: assert property (@(posedge clk) disable iff (rst)
        (ready && mode == CH_ECHO) |-> (!rxf_full && !txf_full));

    a_r10_line_tx_gated: assert property (@(posedge clk) disable iff (rst)
        to_tx |-> tx_ok);

endmodule

// File: rtl/chan_bus_path.sv
module chan_bus_path
    import uart_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  chan_mode_e mode,
    input  logic       bus_valid,
    input  logic       rxf_full,
    input  logic       txf_full,
    input  logic       tx_ok,
    output logic       to_rx,
    output logic       to_tx,
    output logic       overrun_q
);

    route_t rt;
    logic   tx_try;

    always_comb begin
        rt     = bus_route(mode);
        tx_try = bus_valid && rt.to_tx && tx_ok;
        to_tx  = tx_try && !txf_full;
        to_rx  = bus_valid && rt.to_rx && !rxf_full;
    end

    always_ff @(posedge clk) begin
        if (rst) overrun_q <= 1'b0;
        else     overrun_q <= tx_try && txf_full;
    end

    a_r9_overrun_cause: assert property (@(posedge clk) disable iff (rst)
        overrun_q |-> $past(bus_valid && txf_full && tx_ok));

    a_r9_overrun_single: assert property (@(posedge clk) disable iff (rst)
        (overrun_q && $past(overrun_q)) |-> $past(bus_valid, 2));

endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
    import uart_chan_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        chan_mode_cfg,
    input  logic              tx_enable,
    input  logic              tx_disable,
    input  logic              bus_wr_valid,
    input  logic [DATA_W-1:0] bus_wr_data,
    input  logic              line_rx_valid,
    input  logic [DATA_W-1:0] line_rx_data,
    output logic              line_rx_ready,
    input  logic              txf_full,
    output logic              txf_push,
    output logic [DATA_W-1:0] txf_data,
    input  logic              rxf_full,
    output logic              rxf_push,
    output logic [DATA_W-1:0] rxf_data,
    output logic              tx_overrun
);

    chan_mode_e mode_q;
    logic       tx_ok;
    logic       l_rx, l_tx, b_rx, b_tx;

    assign tx_ok = tx_enable && !tx_disable;

    chan_mode_reg u_mode (
        .clk    (clk),
        .rst    (rst),
        .cfg    (chan_mode_cfg),
        .mode_q (mode_q)
    );

    chan_line_path u_line (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode_q),
        .line_valid (line_rx_valid),
        .rxf_full   (rxf_full),
        .txf_full   (txf_full),
        .tx_ok      (tx_ok),
        .ready      (line_rx_ready),
        .to_rx      (l_rx),
        .to_tx      (l_tx)
    );

    chan_bus_path u_bus (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_q),
        .bus_valid (bus_wr_valid),
        .rxf_full  (rxf_full),
        .txf_full  (txf_full),
        .tx_ok     (tx_ok),
        .to_rx     (b_rx),
        .to_tx     (b_tx),
        .overrun_q (tx_overrun)
    );

    always_comb begin
        txf_push = l_tx || b_tx;
        rxf_push = l_rx || b_rx;
        txf_data = l_tx ? line_rx_data : bus_wr_data;
        rxf_data = l_rx ? line_rx_data : bus_wr_data;
    end

    a_r8_no_tx_overflow: assert property (@(posedge clk) disable iff (rst)
        txf_push |-> !txf_full);

    a_r8_no_rx_overflow: assert property (@(posedge clk) disable iff (rst)
        rxf_push |-> !rxf_full);

    a_r10_tx_push_gated: assert property (@(posedge clk) disable iff (rst)
        txf_push |-> (tx_enable && !tx_disable));

    a_r3_single_source_tx: assert property (@(posedge clk) disable iff (rst)
        !(l_tx && b_tx));

    a_r3_single_source_rx: assert property (@(posedge clk) disable iff (rst)
        !(l_rx && b_rx));

endmodule

// File: tb/uart_chan_router_tb_top.sv
module uart_chan_router_tb_top;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    chan_mode_cfg = 2'd0;
    logic          tx_enable = 1'b1;
    logic          tx_disable = 1'b0;
    logic          bus_wr_valid = 1'b0;
    logic [DW-1:0] bus_wr_data = '0;
    logic          line_rx_valid = 1'b0;
    logic [DW-1:0] line_rx_data = '0;
    logic          line_rx_ready;
    logic          txf_full = 1'b0;
    logic          txf_push;
    logic [DW-1:0] txf_data;
    logic          rxf_full = 1'b0;
    logic          rxf_push;
    logic [DW-1:0] rxf_data;
    logic          tx_overrun;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    uart_chan_router #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .chan_mode_cfg(chan_mode_cfg),
        .tx_enable(tx_enable), .tx_disable(tx_disable),
        .bus_wr_valid(bus_wr_valid), .bus_wr_data(bus_wr_data),
        .line_rx_valid(line_rx_valid), .line_rx_data(line_rx_data),
        .line_rx_ready(line_rx_ready),
        .txf_full(txf_full), .txf_push(txf_push), .txf_data(txf_data),
        .rxf_full(rxf_full), .rxf_push(rxf_push), .rxf_data(rxf_data),
        .tx_overrun(tx_overrun)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic quiet();
        bus_wr_valid = 1'b0; line_rx_valid = 1'b0;
        txf_full = 1'b0; rxf_full = 1'b0;
        tx_enable = 1'b1; tx_disable = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk); quiet(); chan_mode_cfg = m;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic offer(input logic bv, input logic [7:0] bd,
                         input logic lv, input logic [7:0] ld);
        bus_wr_valid = bv; bus_wr_data = bd;
        line_rx_valid = lv; line_rx_data = ld;
        #1;
    endtask

    task automatic t_reset();
        chan_mode_cfg = 2'd2;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1", "overrun after reset", tx_overrun, 0);
        chk("R1", "idle txf_push", txf_push, 0);
        chk("R1", "idle rxf_push", rxf_push, 0);
        chk("R1", "ready in normal", line_rx_ready, 1);
        offer(0, 8'h00, 1, 8'h3C);
        chk("R1", "line to rx after reset", rxf_push, 1);
        @(negedge clk); quiet(); #1;
        chk("R2", "mode 2 applied after edge", line_rx_ready, 0);
    endtask

    task automatic t_mode_timing();
        set_mode(2'd2);
        chan_mode_cfg = 2'd0; #1;
        chk("R2", "old mode in change cycle", line_rx_ready, 0);
        @(negedge clk); #1;
        chk("R2", "new mode after edge", line_rx_ready, 1);
    endtask

    task automatic t_normal();
        set_mode(2'd0);
        offer(1, 8'hA1, 1, 8'h5E);
        chk("R3", "tx push", txf_push, 1);
        chk("R3", "tx data", txf_data, 8'hA1);
        chk("R3", "rx push", rxf_push, 1);
        chk("R3", "rx data", rxf_data, 8'h5E);
        @(negedge clk); offer(1, 8'h07, 0, 8'h00);
        chk("R3", "bus only rx push", rxf_push, 0);
        chk("R3", "bus only tx data", txf_data, 8'h07);
    endtask

    task automatic t_echo();
        set_mode(2'd1);
        offer(1, 8'h99, 1, 8'hC3);
        chk("R4", "tx push", txf_push, 1);
        chk("R4", "tx data from line", txf_data, 8'hC3);
        chk("R4", "rx push", rxf_push, 1);
        chk("R4", "rx data", rxf_data, 8'hC3);
        @(negedge clk); offer(1, 8'h99, 0, 8'h00);
        chk("R4", "bus write discarded tx", txf_push, 0);
        chk("R4", "bus write discarded rx", rxf_push, 0);
    endtask

    task automatic t_lloop();
        set_mode(2'd2);
        offer(1, 8'h6B, 1, 8'h11);
        chk("R5", "rx push from bus", rxf_push, 1);
        chk("R5", "rx data is bus byte", rxf_data, 8'h6B);
        chk("R5", "no tx push", txf_push, 0);
        chk("R5", "ready low", line_rx_ready, 0);
        @(negedge clk); offer(0, 8'h00, 1, 8'h11);
        chk("R5", "line ignored rx", rxf_push, 0);
        chk("R5", "line ignored tx", txf_push, 0);
    endtask

    task automatic t_rloop();
        set_mode(2'd3);
        offer(1, 8'h44, 1, 8'hE7);
        chk("R6", "tx push", txf_push, 1);
        chk("R6", "tx data from line", txf_data, 8'hE7);
        chk("R6", "no rx push", rxf_push, 0);
        @(negedge clk); offer(1, 8'h44, 0, 8'h00);
        chk("R6", "bus discarded", txf_push, 0);
    endtask

    task automatic t_ready();
        logic [3:0] exp_n;
        logic [3:0] exp_e;
        logic [3:0] exp_r;
        exp_n = 4'b0101;
        exp_e = 4'b0001;
        exp_r = 4'b0011;
        for (int m = 0; m < 4; m++) begin
            set_mode(m[1:0]);
            for (int f = 0; f < 4; f++) begin
                logic e;
                rxf_full = f[0]; txf_full = f[1]; line_rx_valid = 1'b1; #1;
                case (m)
                    0: e = exp_n[f];
                    1: e = exp_e[f];
                    2: e = 1'b0;
                    default: e = exp_r[f];
                endcase
                chk("R7", $sformatf("ready mode %0d full %0d", m, f), line_rx_ready, e);
                chk("R8", "tx push only when free", txf_push && txf_full, 0);
                chk("R8", "rx push only when free", rxf_push && rxf_full, 0);
                @(negedge clk);
            end
        end
        quiet();
        set_mode(2'd2);
        rxf_full = 1'b1; offer(1, 8'h12, 0, 8'h00);
        chk("R8", "lloop write to full rx dropped", rxf_push, 0);
        @(negedge clk); quiet(); #1;
        chk("R8", "no event on rx drop", tx_overrun, 0);
    endtask

    task automatic t_overrun();
        set_mode(2'd0);
        txf_full = 1'b1; offer(1, 8'hF0, 0, 8'h00);
        chk("R9", "no push when full", txf_push, 0);
        chk("R9", "event not yet", tx_overrun, 0);
        @(negedge clk); quiet(); #1;
        chk("R9", "event one cycle later", tx_overrun, 1);
        @(negedge clk); #1;
        chk("R9", "event lasts one cycle", tx_overrun, 0);
    endtask

    task automatic t_txgate();
        set_mode(2'd0);
        tx_enable = 1'b0; offer(1, 8'h21, 0, 8'h00);
        chk("R10", "enable low blocks bus", txf_push, 0);
        @(negedge clk); tx_enable = 1'b1; tx_disable = 1'b1; txf_full = 1'b1;
        offer(1, 8'h22, 0, 8'h00);
        chk("R10", "disable blocks bus", txf_push, 0);
        @(negedge clk); quiet(); #1;
        chk("R10", "no overrun when disabled", tx_overrun, 0);
        set_mode(2'd3);
        tx_disable = 1'b1; offer(0, 8'h00, 1, 8'h33);
        chk("R10", "ready unaffected", line_rx_ready, 1);
        chk("R10", "line tx push blocked", txf_push, 0);
        @(negedge clk); tx_disable = 1'b0; #1;
        chk("R10", "line tx push allowed", txf_push, 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_mode_timing();
                t_normal();
                t_echo();
                t_lloop();
                t_rloop();
                t_ready();
                t_overrun();
                t_txgate();
            end
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual expired expected done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule